// File: doc/BRIEF.md
# Byte ALU with Carry and Zero Flags

This block is the arithmetic and logic stage of a small register-file microcontroller. Each cycle it takes a 6-bit operation code, the destination register value (operand A), a second operand (operand B, already selected by the surrounding datapath from a register or from the instruction's immediate), and a 4-bit shift control field. It returns the result byte, a write-back enable, and the carry and zero values the operation produces.

The carry and zero flags are held in registers inside the block. They reset to 0 and are loaded from the computed next values only on a cycle where the instruction-valid strobe is high. The stored carry feeds the carry-using operations: add with carry, subtract with borrow, and shifts that take their inserted bit from the carry. Shifts and rotates share one operation code. A direction bit and a coded insert source choose the variant. Compare and test change the flags but never request a write-back.

Top module: `byte_alu_flags`

## Requirements
- R1: The operation is decoded from opcode bits [5:1]: 00000 load, 00101 AND, 00110 OR, 00111 XOR, 01001 test, 01010 compare, 01100 add, 01101 add-with-carry, 01110 subtract, 01111 subtract-with-borrow, 10000 shift/rotate. Any other value gives result 0, no write-back and unchanged flags.
- R2: Load returns operand B with write-back, and the next carry and zero equal the stored flags.
- R3: AND, OR and XOR return the bitwise result with write-back, next carry 0, and next zero set when the result is 0x00.
- R4: Test computes A AND B with no write-back, next carry 0, and next zero set when that value is 0x00.
- R5: Compare computes A minus B with no write-back. Next carry is 1 when A < B (unsigned), and next zero is 1 when A = B.
- R6: Add returns (A+B) mod 256, and add-with-carry returns (A+B+carry) mod 256. Next carry is the ninth sum bit, and next zero is set for a 0x00 result. Example: 0x40, then +0xF0 gives 0x30 with carry 1, then +0xF0 with carry gives 0x21.
- R7: Subtract returns (A−B) mod 256, and subtract-with-borrow returns (A−B−carry) mod 256. Next carry is 1 on borrow, and next zero is set for a 0x00 result. Example: 0x03 minus 0xF0 gives 0x13 with carry 1, then minus 0xF0 with borrow gives 0x22.
- R8: Shift control bit 3 = 1 shifts right: result = {ins, A[7:1]}. Control bits [2:0] pick ins: 00x carry, 01x A[7], 10x A[0] (rotate right), 110 constant 0, 111 constant 1. Example: 0x0F through codes 110,010,111,010,000,000 gives 07, 03, 81, C0, E0, 70.
- R9: Shift control bit 3 = 0 shifts left: result = {A[6:0], ins}, with the same insert codes (01x A[7] is rotate left, 10x A[0]). Example: 0xF0 through codes 110,100,111,100,000,000 gives E0, C0, 81, 03, 07, 0E.
- R10: After any shift or rotate, with write-back asserted, the next carry is the bit shifted out (A[0] right, A[7] left), and the next zero reflects the 8-bit result.
- R11: The stored flags are 0 after reset, take the next values on a clock edge where the valid strobe is high, and hold otherwise.
- R12: Opcode bit 0 (the operand source selector) has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the flags |
| op_valid | input | 1 | Instruction-valid strobe that enables the flag update |
| opcode | input | 6 | Operation code |
| opnd_a | input | W | Destination register value |
| opnd_b | input | W | Second register or immediate value |
| shift_ctl | input | 4 | Bit 3 direction (1 = right), bits [2:0] insert source |
| result | output | W | Operation result |
| wr_en | output | 1 | Write-back request |
| carry_next | output | 1 | Carry value this operation produces |
| zero_next | output | 1 | Zero value this operation produces |
| carry_q | output | 1 | Stored carry flag |
| zero_q | output | 1 | Stored zero flag |

## Verification
The result, write-back, and next-flag outputs are combinational and due in the same cycle the operands are presented. The stored flags change one clock edge later, and only when the strobe was high. The bench drives inputs on the falling edge and compares the combinational outputs a quarter period later, before the rising edge. It compares the stored flags just after that edge against a behavioural model that it updates at the same edge. Because a carry-using result depends on the flag stored one edge earlier, the worked chains advance one operation per cycle with the valid strobe high.

// File: rtl/byte_alu_flags.sv
module byte_alu_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [5:0]   opcode,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [3:0]   shift_ctl,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic         carry_next,
  output logic         zero_next,
  output logic         carry_q,
  output logic         zero_q
);

  localparam logic [4:0] K_LOAD = 5'b00000, K_AND = 5'b00101, K_OR = 5'b00110,
                         K_XOR = 5'b00111, K_TEST = 5'b01001, K_CMP = 5'b01010,
                         K_ADD = 5'b01100, K_ADDC = 5'b01101, K_SUB = 5'b01110,
                         K_SUBC = 5'b01111, K_SHF = 5'b10000;

  wire [4:0] kind    = opcode[5:1];
  wire       use_cin = (kind == K_ADDC) || (kind == K_SUBC);
  wire       cin     = use_cin & carry_q;

  wire [W:0] sum  = {1'b0, opnd_a} + {1'b0, opnd_b} + {{W{1'b0}}, cin};
  wire [W:0] diff = {1'b0, opnd_a} - {1'b0, opnd_b} - {{W{1'b0}}, cin};
  wire [W-1:0] conj = opnd_a & opnd_b;

  logic ins;
  always_comb begin
    unique casez (shift_ctl[2:0])
      3'b00?:  ins = carry_q;
      3'b01?:  ins = opnd_a[W-1];
      3'b10?:  ins = opnd_a[0];
      3'b110:  ins = 1'b0;
      default: ins = 1'b1;
    endcase
  end

  wire         go_right = shift_ctl[3];
  wire [W-1:0] shifted  = go_right ? {ins, opnd_a[W-1:1]} : {opnd_a[W-2:0], ins};
  wire         shf_out  = go_right ? opnd_a[0] : opnd_a[W-1];

  logic keep_flags;
  always_comb begin
    result     = '0;
    wr_en      = 1'b1;
    carry_next = 1'b0;
    keep_flags = 1'b0;
    case (kind)
      K_LOAD: begin result = opnd_b; keep_flags = 1'b1; end
      K_AND:  result = conj;
      K_OR:   result = opnd_a | opnd_b;
      K_XOR:  result = opnd_a ^ opnd_b;
      K_TEST: begin result = conj; wr_en = 1'b0; end
      K_CMP:  begin result = diff[W-1:0]; carry_next = diff[W]; wr_en = 1'b0; end
      K_ADD, K_ADDC: begin result = sum[W-1:0]; carry_next = sum[W]; end
      K_SUB, K_SUBC: begin result = diff[W-1:0]; carry_next = diff[W]; end
      K_SHF:  begin result = shifted; carry_next = shf_out; end
      default: begin wr_en = 1'b0; keep_flags = 1'b1; end
    endcase
    zero_next = (result == '0);
    if (keep_flags) begin
      carry_next = carry_q;
      zero_next  = zero_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else if (op_valid) begin
      carry_q <= carry_next;
      zero_q  <= zero_next;
    end
  end

  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(carry_q) && $stable(zero_q)));
  a_r11_take_next: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (carry_q == $past(carry_next) && zero_q == $past(zero_next)));
  a_r2_load_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_LOAD) |-> (carry_next == carry_q && zero_next == zero_q && result == opnd_b));
  a_r5_cmp_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_CMP) |-> (!wr_en && carry_next == (opnd_a < opnd_b) && zero_next == (opnd_a == opnd_b)));
  a_r4_test_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_TEST) |-> (!wr_en && !carry_next && zero_next == ((opnd_a & opnd_b) == '0)));
  a_r10_shift_out: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_SHF) |-> (wr_en && carry_next == (shift_ctl[3] ? opnd_a[0] : opnd_a[W-1])));
  a_r3_logic_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_AND || kind == K_OR || kind == K_XOR) |-> (wr_en && !carry_next));

endmodule

// File: tb/test_byte_alu_flags.sv
module test_byte_alu_flags;
  logic clk = 0, rst_n = 0, op_valid = 0;
  logic [5:0] opcode = 0;
  logic [7:0] opnd_a = 0, opnd_b = 0;
  logic [3:0] shift_ctl = 0;
  logic [7:0] result;
  logic wr_en, carry_next, zero_next, carry_q, zero_q;

  int n_chk = 0, n_fail = 0;
  int m_c = 0, m_z = 0;
  int s_res, s_wr, s_c, s_z;

  byte_alu_flags i_byte_alu_flags (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [5:0] op, input int a, input int b, input logic [3:0] sh,
                       output int res, output int wr, output int c, output int z);
    int t, ins;
    wr = 1; c = 0; res = 0;
    case (op[5:1])
      5'b00000: res = b;
      5'b00101: res = a & b;
      5'b00110: res = a | b;
      5'b00111: res = a ^ b;
      5'b01001: begin res = a & b; wr = 0; end
      5'b01010: begin t = a - b; res = t & 255; c = (a < b); wr = 0; end
      5'b01100: begin t = a + b; res = t & 255; c = (t > 255); end
      5'b01101: begin t = a + b + m_c; res = t & 255; c = (t > 255); end
      5'b01110: begin t = a - b; res = t & 255; c = (t < 0); end
      5'b01111: begin t = a - b - m_c; res = t & 255; c = (t < 0); end
      5'b10000: begin
        if (sh[2:1] == 0) ins = m_c;
        else if (sh[2:1] == 1) ins = (a >> 7) & 1;
        else if (sh[2:1] == 2) ins = a & 1;
        else ins = sh[0];
        if (sh[3]) begin res = (ins << 7) | (a >> 1); c = a & 1; end
        else begin res = ((a << 1) & 255) | ins; c = (a >> 7) & 1; end
      end
      default: wr = 0;
    endcase
    z = (res == 0);
    if (op[5:1] == 0 || (wr == 0 && op[5:1] != 5'b01001 && op[5:1] != 5'b01010)) begin
      c = m_c; z = m_z;
    end
  endtask

  // one operation per cycle: drive at falling edge, compare combinational outputs before
  // the rising edge, then compare stored flags just after it
  task automatic step(input string tag, input logic [5:0] op, input int a, input int b,
                      input logic [3:0] sh, input logic v);
    int er, ew, ec, ez;
    @(negedge clk);
    opcode = op; opnd_a = a[7:0]; opnd_b = b[7:0]; shift_ctl = sh; op_valid = v;
    #5;
    model(op, a, b, sh, er, ew, ec, ez);
    s_res = result; s_wr = wr_en; s_c = carry_next; s_z = zero_next;
    chk({tag, " result"}, s_res, er);
    chk({tag, " wr_en"}, s_wr, ew);
    chk({tag, " carry_next"}, s_c, ec);
    chk({tag, " zero_next"}, s_z, ez);
    @(posedge clk); #1;
    if (v) begin m_c = ec; m_z = ez; end
    chk({tag, " R11 carry_q"}, carry_q, m_c);
    chk({tag, " R11 zero_q"}, zero_q, m_z);
  endtask

  initial begin
    #2000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #25;
    chk("R11 reset carry", carry_q, 0);
    chk("R11 reset zero", zero_q, 0);
    @(negedge clk); rst_n = 1;

    step("R2 load", 6'b000000, 8'h55, 8'h0F, 0, 1);  chk("R2 load val", s_res, 8'h0F);
    step("R6 add", 6'b011000, 8'h0F, 8'h31, 0, 1);   chk("R6 add val", s_res, 8'h40);
    step("R6 addcy", 6'b011010, 8'h40, 8'hF0, 0, 1); chk("R6 addcy1", s_res, 8'h30); chk("R6 c1", s_c, 1);
    step("R6 addcy", 6'b011011, 8'h30, 8'hF0, 0, 1); chk("R6 addcy2", s_res, 8'h21); chk("R6 c2", s_c, 1);
    step("R2 load flags", 6'b000001, 0, 8'h00, 0, 1); chk("R2 carry kept", carry_q, 1);
    step("R7 sub", 6'b011100, 8'h0F, 8'h0C, 0, 1);   chk("R7 sub val", s_res, 8'h03);
    step("R7 subcy", 6'b011110, 8'h03, 8'hF0, 0, 1); chk("R7 subcy1", s_res, 8'h13); chk("R7 b1", s_c, 1);
    step("R7 subcy", 6'b011111, 8'h13, 8'hF0, 0, 1); chk("R7 subcy2", s_res, 8'h22);
    step("R8 sr0", 6'b100000, 8'h0F, 0, 4'b1110, 1); chk("R8 sr0", s_res, 8'h07);
    step("R8 srx", 6'b100000, 8'h07, 0, 4'b1010, 1); chk("R8 srx", s_res, 8'h03);
    step("R8 sr1", 6'b100000, 8'h03, 0, 4'b1111, 1); chk("R8 sr1", s_res, 8'h81);
    step("R8 srx", 6'b100000, 8'h81, 0, 4'b1011, 1); chk("R8 srx2", s_res, 8'hC0); chk("R10 out1", s_c, 1);
    step("R8 sra", 6'b100000, 8'hC0, 0, 4'b1000, 1); chk("R8 sra", s_res, 8'hE0); chk("R10 out0", s_c, 0);
    step("R8 sra", 6'b100000, 8'hE0, 0, 4'b1001, 1); chk("R8 sra2", s_res, 8'h70);
    step("R9 sl0", 6'b100000, 8'hF0, 0, 4'b0110, 1); chk("R9 sl0", s_res, 8'hE0);
    step("R9 slx", 6'b100000, 8'hE0, 0, 4'b0100, 1); chk("R9 slx", s_res, 8'hC0);
    step("R9 sl1", 6'b100000, 8'hC0, 0, 4'b0111, 1); chk("R9 sl1", s_res, 8'h81);
    step("R9 slx", 6'b100000, 8'h81, 0, 4'b0101, 1); chk("R9 slx2", s_res, 8'h03);
    step("R9 sla", 6'b100000, 8'h03, 0, 4'b0000, 1); chk("R9 sla", s_res, 8'h07);
    step("R9 sla", 6'b100000, 8'h07, 0, 4'b0001, 1); chk("R9 sla2", s_res, 8'h0E);
    step("R8 rr", 6'b100000, 8'h01, 0, 4'b1100, 1);  chk("R8 rr", s_res, 8'h80); chk("R10 rr c", s_c, 1);
    step("R9 rl", 6'b100000, 8'h80, 0, 4'b0010, 1);  chk("R9 rl", s_res, 8'h01);
    step("R10 zero", 6'b100000, 8'h01, 0, 4'b1110, 1); chk("R10 z", s_z, 1);
    step("R5 lt", 6'b010100, 8'h0F, 8'hF0, 0, 1);   chk("R5 lt c", s_c, 1); chk("R5 nowr", s_wr, 0);
    step("R5 eq", 6'b010101, 8'h0F, 8'h0F, 0, 1);   chk("R5 eq z", s_z, 1);
    step("R5 gt", 6'b010100, 8'h0F, 8'h08, 0, 1);   chk("R5 gt c", s_c, 0); chk("R5 gt z", s_z, 0);
    step("R4 test", 6'b010010, 8'h0F, 8'hF0, 0, 1); chk("R4 z", s_z, 1); chk("R4 nowr", s_wr, 0);
    step("R4 test", 6'b010011, 8'h0F, 8'hFF, 0, 1); chk("R4 nz", s_z, 0);
    step("R3 and", 6'b001010, 8'h0F, 8'h33, 0, 1);  chk("R3 and", s_res, 8'h03);
    step("R3 or", 6'b001100, 8'h0F, 8'h33, 0, 1);   chk("R3 or", s_res, 8'h3F);
    step("R3 xor", 6'b001110, 8'h0F, 8'h0F, 0, 1);  chk("R3 xor", s_res, 0); chk("R3 z", s_z, 1);
    step("R11 set c", 6'b011000, 8'hFF, 8'h01, 0, 1);
    step("R11 idle", 6'b011000, 8'h01, 8'h01, 0, 0); chk("R11 held c", carry_q, 1); chk("R11 held z", zero_q, 1);
    step("R1 unknown", 6'b111110, 8'h12, 8'h34, 0, 1); chk("R1 nowr", s_wr, 0); chk("R1 res", s_res, 0);
    chk("R1 flags kept", carry_q, 1);
    step("R12 bit0 a", 6'b011000, 8'h22, 8'h11, 0, 1); chk("R12 sum", s_res, 8'h33);
    step("R12 bit0 b", 6'b011001, 8'h22, 8'h11, 0, 1); chk("R12 sum", s_res, 8'h33);

    for (int i = 0; i < 400; i++) begin
      logic [5:0] op;
      case ($urandom_range(0, 11))
        0: op = 6'b000000; 1: op = 6'b001010; 2: op = 6'b001100; 3: op = 6'b001110;
        4: op = 6'b010010; 5: op = 6'b010100; 6: op = 6'b011000; 7: op = 6'b011010;
        8: op = 6'b011100; 9: op = 6'b011110; 10: op = 6'b100000;
        default: op = 6'($urandom);
      endcase
      op[0] = 1'($urandom);
      step("R1 mix", op, $urandom_range(0, 255), $urandom_range(0, 255),
           4'($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule